// File: doc/BRIEF.md
# Interrupt Priority Threshold Arbiter

This block chooses, for one interrupt target context, which source to present. Every source supplies a pending flag, a claimed flag, an enable flag for this context and a small priority value. The context supplies a threshold. The block keeps only the eligible sources, drops every source whose priority is not strictly above the threshold, and selects the highest remaining priority. On a tie, the lowest source number wins. It reports the winning source number and raises an interrupt request whenever that number is nonzero.

Source number 0 is reserved to mean "nothing to service", so its inputs never take part in the selection. The flag vectors arrive as whole 32-bit words. Bits at or above the configured source count are padding and are ignored. Selection is a balanced two-input comparison tree that carries a valid flag, a source number and a priority at each node. The result is held in one output register, so it appears one clock after the inputs. Several copies, one per context, can share the same pending, claimed and priority vectors while each has its own enables and threshold.

Top module: `prio_thresh_arb`

## Requirements
- R1: A source can be selected only when its pending bit is 1, its claimed bit is 0 and its enable bit is 1. In each flag vector, bit i belongs to source i.
- R2: A source can be selected only when its priority is strictly greater than `thresh_i`. A priority equal to the threshold never wins.
- R3: Among the sources that qualify, the selected one has the greatest priority. The priority of source i is `prio_i[i*PRIO_W +: PRIO_W]`.
- R4: When several qualifying sources share the greatest priority, the lowest source number is selected.
- R5: `win_id_o` equal to 0 means no request. Source 0 is never selected, whatever its inputs are.
- R6: `irq_o` is 1 exactly when `win_id_o` is nonzero.
- R7: Flag bits at positions NUM_SRC and above (up to the 32-bit word boundary) have no effect, and `win_id_o` is always below NUM_SRC.
- R8: A source with priority 0 is never selected.
- R9: While `rst_ni` is 0, `win_id_o` and `irq_o` are 0. Otherwise they reflect the inputs sampled at the previous rising clock edge (one-cycle latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pending_i | input | 32*ceil(NUM_SRC/32) | Pending flag per source |
| claimed_i | input | 32*ceil(NUM_SRC/32) | Claimed (in service) flag per source |
| enable_i | input | 32*ceil(NUM_SRC/32) | Enable flag per source for this context |
| prio_i | input | NUM_SRC*PRIO_W | Packed priority per source |
| thresh_i | input | PRIO_W | Context threshold |
| win_id_o | output | clog2(NUM_SRC) | Selected source number, 0 for none |
| irq_o | output | 1 | Interrupt request to the context |

## Verification
A fault inside the comparison tree, such as a mis-ordered node, an inverted tie rule or a non-strict threshold test, shows up as a wrong `win_id_o` exactly one clock after the input pattern that exercises it. There is no hidden state that could hide a fault until later. A leaf that ignores a claimed or enable bit selects a source that should have been masked. A bad guard on the padding bits or on source 0 produces an out-of-range or zero-source win, which the bench and the bound checker both see at the next edge. Directed rows target each ordering rule, and randomized vectors are compared against a sequential ascending-scan model.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
    localparam int FLAG_WORD_W = 32;

    // number of 32-bit flag words needed for n sources
    function automatic int flag_words(input int n);
        return (n + FLAG_WORD_W - 1) / FLAG_WORD_W;
    endfunction
endpackage

// File: rtl/prio_arb_leaf.sv
module prio_arb_leaf #(
    parameter int PRIO_W = 3,
    parameter int ID_W   = 6,
    parameter int SRC_ID = 1
) (
    input  logic              pend_i,
    input  logic              clm_i,
    input  logic              en_i,
    input  logic [PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0] thr_i,
    output logic              cand_v_o,
    output logic [ID_W-1:0]   cand_id_o,
    output logic [PRIO_W-1:0] cand_p_o
);
    logic eligible;

    always_comb begin
        eligible  = pend_i & ~clm_i & en_i;
        // strict comparison: equal to threshold (and priority 0) never qualifies
        cand_v_o  = eligible && (prio_i > thr_i);
        cand_id_o = ID_W'(SRC_ID);
        cand_p_o  = prio_i;
    end
endmodule

// File: rtl/prio_arb_node.sv
module prio_arb_node #(
    parameter int PRIO_W = 3,
    parameter int ID_W   = 6
) (
    input  logic              lo_v_i,
    input  logic [ID_W-1:0]   lo_id_i,
    input  logic [PRIO_W-1:0] lo_p_i,
    input  logic              hi_v_i,
    input  logic [ID_W-1:0]   hi_id_i,
    input  logic [PRIO_W-1:0] hi_p_i,
    output logic              win_v_o,
    output logic [ID_W-1:0]   win_id_o,
    output logic [PRIO_W-1:0] win_p_o
);
    logic take_hi;

    always_comb begin
        // the lower-numbered branch keeps ties
        take_hi  = hi_v_i && (!lo_v_i || (hi_p_i > lo_p_i));
        win_v_o  = lo_v_i | hi_v_i;
        win_id_o = take_hi ? hi_id_i : lo_id_i;
        win_p_o  = take_hi ? hi_p_i  : lo_p_i;
    end
endmodule

// File: rtl/prio_thresh_arb.sv
module prio_thresh_arb #(
    parameter int NUM_SRC = 48,
    parameter int PRIO_W  = 3
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic [32*((NUM_SRC+31)/32)-1:0]  pending_i,
    input  logic [32*((NUM_SRC+31)/32)-1:0]  claimed_i,
    input  logic [32*((NUM_SRC+31)/32)-1:0]  enable_i,
    input  logic [NUM_SRC*PRIO_W-1:0]        prio_i,
    input  logic [PRIO_W-1:0]                thresh_i,
    output logic [$clog2(NUM_SRC)-1:0]       win_id_o,
    output logic                             irq_o
);
    localparam int VEC_W  = prio_arb_pkg::FLAG_WORD_W * prio_arb_pkg::flag_words(NUM_SRC);
    localparam int ID_W   = $clog2(NUM_SRC);
    localparam int LEAVES = 1 << ID_W;
    localparam int NODES  = 2 * LEAVES - 1;
    localparam int LEAF0  = LEAVES - 1;

    logic [NODES-1:0] node_v;
    logic [ID_W-1:0]   node_id [NODES];
    logic [PRIO_W-1:0] node_p  [NODES];

    // leaf stage: eligibility and threshold per real source
    for (genvar g = 0; g < LEAVES; g++) begin : g_leaf
        if (g > 0 && g < NUM_SRC) begin : g_real
            prio_arb_leaf #(
                .PRIO_W (PRIO_W),
                .ID_W   (ID_W),
                .SRC_ID (g)
            ) u_leaf (
                .pend_i    (pending_i[g]),
                .clm_i     (claimed_i[g]),
                .en_i      (enable_i[g]),
                .prio_i    (prio_i[g*PRIO_W +: PRIO_W]),
                .thr_i     (thresh_i),
                .cand_v_o  (node_v[LEAF0+g]),
                .cand_id_o (node_id[LEAF0+g]),
                .cand_p_o  (node_p[LEAF0+g])
            );
        end else begin : g_void
            // reserved source 0 and padding leaves never qualify
            assign node_v[LEAF0+g]  = 1'b0;
            assign node_id[LEAF0+g] = ID_W'(g);
            assign node_p[LEAF0+g]  = '0;
        end
    end

    // balanced comparison tree, heap layout: children of n are 2n+1, 2n+2
    for (genvar n = 0; n < LEAF0; n++) begin : g_node
        prio_arb_node #(
            .PRIO_W (PRIO_W),
            .ID_W   (ID_W)
        ) u_node (
            .lo_v_i   (node_v[2*n+1]),
            .lo_id_i  (node_id[2*n+1]),
            .lo_p_i   (node_p[2*n+1]),
            .hi_v_i   (node_v[2*n+2]),
            .hi_id_i  (node_id[2*n+2]),
            .hi_p_i   (node_p[2*n+2]),
            .win_v_o  (node_v[n]),
            .win_id_o (node_id[n]),
            .win_p_o  (node_p[n])
        );
    end

    // bits with no selection role: source 0 and word padding
    logic unused_flags;
    if (VEC_W > NUM_SRC) begin : g_pad
        assign unused_flags = ^{pending_i[0], claimed_i[0], enable_i[0],
                                prio_i[PRIO_W-1:0], node_p[0],
                                pending_i[VEC_W-1:NUM_SRC],
                                claimed_i[VEC_W-1:NUM_SRC],
                                enable_i[VEC_W-1:NUM_SRC]};
    end else begin : g_nopad
        assign unused_flags = ^{pending_i[0], claimed_i[0], enable_i[0],
                                prio_i[PRIO_W-1:0], node_p[0]};
    end

    // output stage: next value, then register
    logic [ID_W-1:0] id_d;
    logic            irq_d;

    always_comb begin
        id_d  = node_v[0] ? node_id[0] : '0;
        irq_d = node_v[0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            win_id_o <= '0;
            irq_o    <= 1'b0;
        end else begin
            win_id_o <= id_d;
            irq_o    <= irq_d;
        end
    end
endmodule

// File: rtl/prio_thresh_arb_chk.sv
module prio_thresh_arb_chk #(
    parameter int NUM_SRC = 48,
    parameter int PRIO_W  = 3
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic [NUM_SRC-1:0]         pend_i,
    input logic [NUM_SRC-1:0]         clm_i,
    input logic [NUM_SRC-1:0]         en_i,
    input logic [NUM_SRC*PRIO_W-1:0]  prio_i,
    input logic [PRIO_W-1:0]          thr_i,
    input logic [$clog2(NUM_SRC)-1:0] win_id,
    input logic                       irq
);
    localparam int ID_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0]        pend_q, clm_q, en_q;
    logic [NUM_SRC*PRIO_W-1:0] prio_q;
    logic [PRIO_W-1:0]         thr_q;
    logic                      armed_q;

    always_ff @(posedge clk_i) begin
        pend_q <= pend_i;
        clm_q  <= clm_i;
        en_q   <= en_i;
        prio_q <= prio_i;
        thr_q  <= thr_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) armed_q <= 1'b0;
        else         armed_q <= 1'b1;
    end

    // ascending scan over the sampled inputs
    logic [ID_W-1:0]   scan_id;
    logic [PRIO_W-1:0] scan_best;
    logic [PRIO_W-1:0] win_p;
    logic              win_elig;

    always_comb begin
        scan_id   = '0;
        scan_best = thr_q;
        for (int i = 1; i < NUM_SRC; i++) begin
            if (pend_q[i] && !clm_q[i] && en_q[i] &&
                prio_q[i*PRIO_W +: PRIO_W] > scan_best) begin
                scan_best = prio_q[i*PRIO_W +: PRIO_W];
                scan_id   = ID_W'(i);
            end
        end
        win_p    = '0;
        win_elig = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (int'(win_id) == i) begin
                win_p    = prio_q[i*PRIO_W +: PRIO_W];
                win_elig = pend_q[i] & ~clm_q[i] & en_q[i];
            end
        end
    end

    // R6
    irq_matches_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq == (win_id != '0));

    // R7
    id_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(win_id) < NUM_SRC);

    // R1
    winner_eligible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && irq) |-> win_elig);

    // R2 and R8
    above_thresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && irq) |-> (win_p > thr_q));

    // R3 and R4
    matches_scan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q |-> (win_id == scan_id));
endmodule

bind prio_thresh_arb prio_thresh_arb_chk #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W)
) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pending_i[NUM_SRC-1:0]),
    .clm_i  (claimed_i[NUM_SRC-1:0]),
    .en_i   (enable_i[NUM_SRC-1:0]),
    .prio_i (prio_i),
    .thr_i  (thresh_i),
    .win_id (win_id_o),
    .irq    (irq_o)
);

// File: tb/prio_thresh_arb_test.sv
module prio_thresh_arb_test;
    localparam int NUM_SRC = 48;
    localparam int PRIO_W  = 3;
    localparam int VEC_W   = 64;
    localparam int ID_W    = 6;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [VEC_W-1:0]          pend = '0, clm = '0, en = '0;
    logic [NUM_SRC*PRIO_W-1:0] prio = '0;
    logic [PRIO_W-1:0]         thr = '0;
    logic [ID_W-1:0]           win_id;
    logic                      irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    prio_thresh_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) uut (
        .clk_i (clk), .rst_ni (rst_n),
        .pending_i (pend), .claimed_i (clm), .enable_i (en),
        .prio_i (prio), .thresh_i (thr),
        .win_id_o (win_id), .irq_o (irq)
    );

    typedef struct packed {
        logic [63:0] pend;
        logic [63:0] clm;
        logic [63:0] en;
        logic [2:0]  base;
        logic [5:0]  hi_src;
        logic [2:0]  hi_p;
        logic [2:0]  thr;
        logic [5:0]  exp_id;
    } row_t;

    localparam logic [63:0] ALL = 64'hFFFF_FFFF_FFFF_FFFF;

    localparam row_t TBL [9] = '{
        '{ALL, 64'h0, ALL, 3'd1, 6'd20, 3'd5, 3'd0, 6'd20},                     // R3 single highest
        '{ALL, 64'h0, ALL, 3'd1, 6'd20, 3'd5, 3'd5, 6'd0},                      // R2 equal to threshold
        '{ALL, 64'h0, ALL, 3'd1, 6'd20, 3'd5, 3'd4, 6'd20},                     // R2 one above threshold
        '{ALL, 64'h0, ALL, 3'd3, 6'd9,  3'd3, 3'd2, 6'd1},                      // R4 tie, lowest wins
        '{64'hFFFF_0000_0000_0001, 64'h0, ALL, 3'd7, 6'd0, 3'd7, 3'd0, 6'd0},   // R5 R7 source 0 and padding only
        '{ALL, 64'h7FFF_FFFF, ALL, 3'd2, 6'd20, 3'd6, 3'd1, 6'd31},             // R1 claimed masked
        '{ALL, 64'h0, 64'h0000_0100_0000_0000, 3'd0, 6'd40, 3'd0, 3'd0, 6'd0},  // R8 priority 0
        '{ALL, 64'h0, 64'h0000_0100_0000_0000, 3'd0, 6'd40, 3'd1, 3'd0, 6'd40}, // R1 only enabled source
        '{ALL, 64'h0, ALL, 3'd0, 6'd47, 3'd7, 3'd6, 6'd47}                      // R3 last source
    };

    function automatic logic [ID_W-1:0] ref_scan(
        input logic [VEC_W-1:0] p, input logic [VEC_W-1:0] c,
        input logic [VEC_W-1:0] e, input logic [NUM_SRC*PRIO_W-1:0] pr,
        input logic [PRIO_W-1:0] t);
        logic [PRIO_W-1:0] best = t;
        logic [ID_W-1:0]   id = '0;
        for (int i = 1; i < NUM_SRC; i++) begin
            if (p[i] && !c[i] && e[i] && pr[i*PRIO_W +: PRIO_W] > best) begin
                best = pr[i*PRIO_W +: PRIO_W];
                id   = ID_W'(i);
            end
        end
        return id;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive_row(input row_t r);
        pend = r.pend; clm = r.clm; en = r.en; thr = r.thr;
        for (int i = 0; i < NUM_SRC; i++)
            prio[i*PRIO_W +: PRIO_W] = (i == int'(r.hi_src)) ? r.hi_p : r.base;
    endtask

    initial begin
        // R9 reset state with an eligible source present
        drive_row(TBL[0]);
        repeat (3) @(negedge clk);
        check("R9 reset id", int'(win_id), 0);
        check("R9 reset irq", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 first result", int'(win_id), 20);

        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            drive_row(TBL[k]);
            @(negedge clk);
            check($sformatf("table row %0d id", k), int'(win_id), int'(TBL[k].exp_id));
            check($sformatf("R6 table row %0d irq", k), int'(irq), int'(TBL[k].exp_id != 0));
        end

        // R9 one-cycle latency: change inputs, old result still held before the edge
        @(negedge clk);
        drive_row(TBL[3]);
        @(negedge clk);
        drive_row(TBL[8]);
        #1;
        check("R9 latency hold", int'(win_id), 1);
        @(negedge clk);
        check("R9 latency update", int'(win_id), 47);

        // R3 R4 randomized against the ascending-scan model
        for (int k = 0; k < 300; k++) begin
            logic [ID_W-1:0] exp;
            @(negedge clk);
            pend = {$urandom, $urandom};
            clm  = {$urandom, $urandom} & {$urandom, $urandom};
            en   = {$urandom, $urandom};
            for (int i = 0; i < NUM_SRC; i++) prio[i*PRIO_W +: PRIO_W] = PRIO_W'($urandom);
            thr  = PRIO_W'($urandom % 6);
            exp  = ref_scan(pend, clm, en, prio, thr);
            @(negedge clk);
            check("R3 R4 random id", int'(win_id), int'(exp));
            check("R6 random irq", int'(irq), int'(exp != 0));
        end

        // R9 reset again clears a live request
        @(negedge clk);
        drive_row(TBL[0]);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9 async clear", int'(win_id), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule